// File: doc/BRIEF.md
# Zoned Translation Lookaside Buffer

This block is a small, fully associative translation buffer for an embedded processor whose software loads every entry explicitly. Each slot holds a valid flag, an effective page base, a real page base, the page size as a power of two, a process tag and an attribute byte. The upper nibble of the attribute byte picks one of sixteen protection zones. A lookup compares one address and process tag against every slot in the same cycle. One clock later it reports whether any slot hit, which slot won, the translated real address, and the 2-bit code of the winning slot's zone. It also reports whether that code overrides the page's own permission checks for the current privilege level.

Software keeps the contents up to date through three paths. A write port loads a whole slot. A flush pulse clears every slot. A targeted invalidate clears the single slot that would translate a given address and process tag. Changes take effect at the next clock edge. The design has no sequencer: the only state is the slot array and the output register, so each path finishes in one cycle.

Top module: `ztlb_top`

## Requirements
- R1: A slot whose valid flag is 0 never hits, for any address or process tag.
- R2: A slot whose process tag is 0 hits under any current tag. Any other slot hits only when its tag equals the current tag.
- R3: The page size field `lg` (5 bits) gives the page size as 2^lg bytes. The page mask is all ones shifted left by `lg`, and a slot hits only when (address AND mask) equals its stored effective base.
- R4: On a hit, the real address is (stored real base AND mask) OR (address AND NOT mask).
- R5: When several slots hit, the slot with the lowest index wins, and its index is reported on `hit_idx`.
- R6: The zone number is attribute bits [7:4] of the winning slot. Its 2-bit code is `zone_map` bits [p+1:p], with p = (28 − 2×zone) mod 32, so zone 14 reads bits [1:0] and zone 15 reads bits [31:30].
- R7: `zone_ovr` is 1 when the code is 3, whatever the privilege. It is also 1 when the code is 2 and `lk_sup` is 1. In every other case (code 0, code 1, or code 2 with `lk_sup` = 0) it is 0.
- R8: On a miss, `hit`, `hit_idx`, `real_addr`, `zone_code` and `zone_ovr` are all 0.
- R9: Results appear exactly one clock after the lookup inputs are presented. A lookup in the same cycle as a write or invalidate uses the contents from before that edge.
- R10: When `wr_en` is 1, slot `wr_idx` takes all the write fields at the next edge, and its valid flag becomes `wr_valid`.
- R11: `inv_all` clears every valid flag at the next edge. It also wins over a write in the same cycle.
- R12: `inv_va_en` clears only the lowest-index slot that matches `inv_va` and `inv_pid` under the R1–R3 rules, judged on the old contents. If no slot matches, nothing changes. A write to that same slot in the same cycle wins over the invalidate.
- R13: While reset is asserted, every slot is invalid and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_addr | input | 32 | Lookup effective address |
| lk_pid | input | 8 | Current process tag |
| lk_sup | input | 1 | 1 = supervisor, 0 = user |
| zone_map | input | 32 | Sixteen 2-bit zone codes |
| wr_en | input | 1 | Load slot strobe |
| wr_idx | input | 4 | Slot to load |
| wr_valid | input | 1 | Valid flag to load |
| wr_epn | input | 32 | Effective page base to load |
| wr_rpn | input | 32 | Real page base to load |
| wr_lg | input | 5 | log2 of page size to load |
| wr_pid | input | 8 | Process tag to load |
| wr_attr | input | 8 | Attribute byte to load; bits [7:4] select the zone |
| inv_all | input | 1 | Flush every slot |
| inv_va_en | input | 1 | Targeted invalidate strobe |
| inv_va | input | 32 | Address for targeted invalidate |
| inv_pid | input | 8 | Process tag for targeted invalidate |
| hit | output | 1 | Registered hit flag |
| hit_idx | output | 4 | Winning slot index |
| real_addr | output | 32 | Translated address |
| zone_code | output | 2 | Zone code of the winning slot |
| zone_ovr | output | 1 | Zone override applied |

## Verification
A lookup can share a cycle with a write or an invalidate, and a write can share a cycle with an invalidate. Both pairings are driven on purpose. A lookup aimed at a slot that is being rewritten must still return the old translation. A targeted invalidate and a write to the same slot must leave the new contents valid. A flush together with a write must leave every slot empty. Each result is judged against a bench-side table, which is updated with the same precedence the requirements give. The following lookups then show which side won.

// File: rtl/ztlb_pkg.sv
package ztlb_pkg;
    localparam int TLB_N      = 16;
    localparam int TLB_AW     = 32;
    localparam int TLB_PIDW   = 8;
    localparam int TLB_ATTRW  = 8;
    localparam int TLB_LGW    = 5;
    localparam int TLB_ZMW    = 32;
    localparam int ZSEL_LSB   = 4;
    localparam int ZSEL_W     = 4;
    localparam int ZPOS_W     = $clog2(TLB_ZMW);
    localparam int ZPOS_TOP   = 28;

    typedef struct packed {
        logic                 vld;
        logic [TLB_AW-1:0]    epn;
        logic [TLB_AW-1:0]    rpn;
        logic [TLB_LGW-1:0]   lg;
        logic [TLB_PIDW-1:0]  pid;
        logic [TLB_ATTRW-1:0] attr;
    } ztlb_ent_t;

    typedef enum logic [1:0] {
        ZC_PAGE_A = 2'd0,
        ZC_PAGE_B = 2'd1,
        ZC_SUPER  = 2'd2,
        ZC_OPEN   = 2'd3
    } zone_code_e;

    function automatic logic [TLB_AW-1:0] page_mask(input logic [TLB_LGW-1:0] lg);
        return {TLB_AW{1'b1}} << lg;
    endfunction
endpackage

// File: rtl/ztlb_match.sv
module ztlb_match
    import ztlb_pkg::*;
#(
    parameter int N = TLB_N,
    localparam int IW = $clog2(N)
) (
    input  ztlb_ent_t [N-1:0]     ents,
    input  logic [TLB_AW-1:0]     addr,
    input  logic [TLB_PIDW-1:0]   pid,
    output logic                  any,
    output logic [IW-1:0]         idx
);
    logic [N-1:0] hitv;
    logic [N-1:0] unused_bits;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hitv[g] = ents[g].vld
                      && (ents[g].pid == '0 || ents[g].pid == pid)
                      && ((addr & page_mask(ents[g].lg)) == ents[g].epn);
        assign unused_bits[g] = ^{ents[g].rpn, ents[g].attr};
    end

    // lowest index wins: scan downward so the last assignment is the smallest
    always_comb begin
        any = |hitv;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hitv[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/ztlb_zone.sv
module ztlb_zone
    import ztlb_pkg::*;
(
    input  logic [ZSEL_W-1:0]   zsel,
    input  logic [TLB_ZMW-1:0]  zmap,
    input  logic                sup,
    output zone_code_e          code,
    output logic                ovr
);
    logic [ZPOS_W-1:0] pos;

    // wraps modulo the map width, so the highest zones land at the top bits
    assign pos = ZPOS_W'(ZPOS_TOP) - ZPOS_W'({zsel, 1'b0});

    always_comb begin
        code = zone_code_e'(zmap[pos +: 2]);
        unique case (code)
            ZC_OPEN:   ovr = 1'b1;
            ZC_SUPER:  ovr = sup;
            ZC_PAGE_A,
            ZC_PAGE_B: ovr = 1'b0;
            default:   ovr = 1'b0;
        endcase
    end
endmodule

// File: rtl/ztlb_store.sv
module ztlb_store
    import ztlb_pkg::*;
#(
    parameter int N = TLB_N,
    localparam int IW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  ztlb_ent_t         wr_ent,
    input  logic              inv_all,
    input  logic              inv_hit,
    input  logic [IW-1:0]     inv_idx,
    output ztlb_ent_t [N-1:0] ents
);
    // precedence by order: targeted clear, then write, then flush
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ents <= '0;
        end else begin
            if (inv_hit) ents[inv_idx].vld <= 1'b0;
            if (wr_en)   ents[wr_idx]      <= wr_ent;
            if (inv_all) begin
                for (int i = 0; i < N; i++) ents[i].vld <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ztlb_top.sv
module ztlb_top
    import ztlb_pkg::*;
#(
    parameter int N = TLB_N,
    localparam int IW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TLB_AW-1:0]    lk_addr,
    input  logic [TLB_PIDW-1:0]  lk_pid,
    input  logic                 lk_sup,
    input  logic [TLB_ZMW-1:0]   zone_map,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  logic                 wr_valid,
    input  logic [TLB_AW-1:0]    wr_epn,
    input  logic [TLB_AW-1:0]    wr_rpn,
    input  logic [TLB_LGW-1:0]   wr_lg,
    input  logic [TLB_PIDW-1:0]  wr_pid,
    input  logic [TLB_ATTRW-1:0] wr_attr,
    input  logic                 inv_all,
    input  logic                 inv_va_en,
    input  logic [TLB_AW-1:0]    inv_va,
    input  logic [TLB_PIDW-1:0]  inv_pid,
    output logic                 hit,
    output logic [IW-1:0]        hit_idx,
    output logic [TLB_AW-1:0]    real_addr,
    output logic [1:0]           zone_code,
    output logic                 zone_ovr
);
    ztlb_ent_t [N-1:0] ents;
    ztlb_ent_t         wr_ent;
    logic [N-1:0]      ent_vld;
    logic              lk_any, iv_any;
    logic [IW-1:0]     lk_idx, iv_idx;
    logic [TLB_AW-1:0] lk_mask, raddr_d;
    zone_code_e        z_code;
    logic              z_ovr;

    always_comb begin
        wr_ent.vld  = wr_valid;
        wr_ent.epn  = wr_epn;
        wr_ent.rpn  = wr_rpn;
        wr_ent.lg   = wr_lg;
        wr_ent.pid  = wr_pid;
        wr_ent.attr = wr_attr;
    end

    for (genvar g = 0; g < N; g++) begin : g_vld
        assign ent_vld[g] = ents[g].vld;
    end

    ztlb_store #(.N(N)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_ent  (wr_ent),
        .inv_all (inv_all),
        .inv_hit (inv_va_en && iv_any),
        .inv_idx (iv_idx),
        .ents    (ents)
    );

    ztlb_match #(.N(N)) u_lk_match (
        .ents (ents),
        .addr (lk_addr),
        .pid  (lk_pid),
        .any  (lk_any),
        .idx  (lk_idx)
    );

    ztlb_match #(.N(N)) u_iv_match (
        .ents (ents),
        .addr (inv_va),
        .pid  (inv_pid),
        .any  (iv_any),
        .idx  (iv_idx)
    );

    ztlb_zone u_zone (
        .zsel (ents[lk_idx].attr[ZSEL_LSB +: ZSEL_W]),
        .zmap (zone_map),
        .sup  (lk_sup),
        .code (z_code),
        .ovr  (z_ovr)
    );

    assign lk_mask = page_mask(ents[lk_idx].lg);
    assign raddr_d = (ents[lk_idx].rpn & lk_mask) | (lk_addr & ~lk_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit       <= 1'b0;
            hit_idx   <= '0;
            real_addr <= '0;
            zone_code <= '0;
            zone_ovr  <= 1'b0;
        end else if (lk_any) begin
            hit       <= 1'b1;
            hit_idx   <= lk_idx;
            real_addr <= raddr_d;
            zone_code <= z_code;
            zone_ovr  <= z_ovr;
        end else begin
            hit       <= 1'b0;
            hit_idx   <= '0;
            real_addr <= '0;
            zone_code <= '0;
            zone_ovr  <= 1'b0;
        end
    end
endmodule

// File: rtl/ztlb_chk.sv
module ztlb_chk #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lk_sup,
    input logic          wr_en,
    input logic [IW-1:0] wr_idx,
    input logic          wr_valid,
    input logic          inv_all,
    input logic          inv_va_en,
    input logic          hit,
    input logic [IW-1:0] hit_idx,
    input logic [31:0]   real_addr,
    input logic [1:0]    zone_code,
    input logic          zone_ovr,
    input logic [N-1:0]  ent_vld
);
    AST_HIT_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((($past(ent_vld) >> hit_idx) & N'(1)) != '0)); // R1

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_idx == '0 && real_addr == '0 && zone_code == 2'd0 && !zone_ovr)); // R8

    AST_OVR_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        zone_ovr |-> (zone_code == 2'd3 || (zone_code == 2'd2 && $past(lk_sup)))); // R7

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !inv_all) |=> ent_vld[$past(wr_idx)] == $past(wr_valid)); // R10

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> ent_vld == '0); // R11

    AST_TARGET_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_va_en && !inv_all && !wr_en) |=> $countones($past(ent_vld) & ~ent_vld) <= 1); // R12

    AST_QUIET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!inv_va_en && !inv_all && !wr_en) |=> $stable(ent_vld)); // R10
endmodule

bind ztlb_top ztlb_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_sup    (lk_sup),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_valid  (wr_valid),
    .inv_all   (inv_all),
    .inv_va_en (inv_va_en),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .real_addr (real_addr),
    .zone_code (zone_code),
    .zone_ovr  (zone_ovr),
    .ent_vld   (ent_vld)
);

// File: tb/ztlb_top_bench.sv
`timescale 1ns/1ps
module ztlb_top_bench;
    localparam int N = 16;
    localparam int WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_addr = '0;
    logic [7:0]  lk_pid = '0;
    logic        lk_sup = 1'b0;
    logic [31:0] zone_map = 32'hE4E4_E4E4;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_epn = '0, wr_rpn = '0;
    logic [4:0]  wr_lg = '0;
    logic [7:0]  wr_pid = '0, wr_attr = '0;
    logic        inv_all = 1'b0;
    logic        inv_va_en = 1'b0;
    logic [31:0] inv_va = '0;
    logic [7:0]  inv_pid = '0;
    logic        hit;
    logic [3:0]  hit_idx;
    logic [31:0] real_addr;
    logic [1:0]  zone_code;
    logic        zone_ovr;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // bench-side table
    logic        m_vld [N];
    logic [31:0] m_epn [N];
    logic [31:0] m_rpn [N];
    logic [4:0]  m_lg  [N];
    logic [7:0]  m_pid [N];
    logic [7:0]  m_attr[N];

    always #4 clk = ~clk;

    ztlb_top u_ztlb_top (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_pid(lk_pid), .lk_sup(lk_sup),
        .zone_map(zone_map), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_epn(wr_epn), .wr_rpn(wr_rpn), .wr_lg(wr_lg), .wr_pid(wr_pid), .wr_attr(wr_attr),
        .inv_all(inv_all), .inv_va_en(inv_va_en), .inv_va(inv_va), .inv_pid(inv_pid),
        .hit(hit), .hit_idx(hit_idx), .real_addr(real_addr), .zone_code(zone_code),
        .zone_ovr(zone_ovr)
    );

    function automatic bit m_match(int i, logic [31:0] a, logic [7:0] p);
        logic [31:0] msk;
        msk = 32'hFFFF_FFFF << m_lg[i];
        return m_vld[i] && (m_pid[i] == 8'd0 || m_pid[i] == p) && ((a & msk) == m_epn[i]);
    endfunction

    function automatic int zpos(int z);
        return (28 - 2 * z + 32) % 32;
    endfunction

    logic        e_hit;
    logic [3:0]  e_idx;
    logic [31:0] e_ra;
    logic [1:0]  e_zc;
    logic        e_zo;

    task automatic model_lookup();
        logic [31:0] msk;
        int z;
        e_hit = 0; e_idx = 0; e_ra = 0; e_zc = 0; e_zo = 0;
        for (int i = 0; i < N; i++) begin
            if (!e_hit && m_match(i, lk_addr, lk_pid)) begin
                e_hit = 1;
                e_idx = 4'(i);
                msk   = 32'hFFFF_FFFF << m_lg[i];
                e_ra  = (m_rpn[i] & msk) | (lk_addr & ~msk);
                z     = int'(m_attr[i][7:4]);
                e_zc  = 2'((zone_map >> zpos(z)) & 32'h3);
                e_zo  = (e_zc == 2'd3) || (e_zc == 2'd2 && lk_sup);
            end
        end
    endtask

    // one clock: expect from old table, update table by stated precedence, compare
    task automatic tick(input string tag);
        bool_found: begin end
        model_lookup();
        if (inv_va_en) begin
            for (int i = 0; i < N; i++) begin
                if (m_match(i, inv_va, inv_pid)) begin
                    m_vld[i] = 1'b0;
                    break;
                end
            end
        end
        if (wr_en) begin
            m_vld[wr_idx] = wr_valid; m_epn[wr_idx] = wr_epn; m_rpn[wr_idx] = wr_rpn;
            m_lg[wr_idx] = wr_lg; m_pid[wr_idx] = wr_pid; m_attr[wr_idx] = wr_attr;
        end
        if (inv_all) for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; inv_all = 1'b0; inv_va_en = 1'b0;
        checks++;
        if (hit !== e_hit || hit_idx !== e_idx || real_addr !== e_ra ||
            zone_code !== e_zc || zone_ovr !== e_zo) begin
            failures++;
            $display("FAIL %s: got hit=%0b idx=%0d ra=%h zc=%0d zo=%0b exp hit=%0b idx=%0d ra=%h zc=%0d zo=%0b",
                     tag, hit, hit_idx, real_addr, zone_code, zone_ovr,
                     e_hit, e_idx, e_ra, e_zc, e_zo);
        end
    endtask

    task automatic set_wr(input int i, input logic v, input logic [31:0] epn,
                          input logic [31:0] rpn, input logic [4:0] lg,
                          input logic [7:0] pid, input logic [7:0] attr);
        wr_en = 1'b1; wr_idx = 4'(i); wr_valid = v; wr_epn = epn; wr_rpn = rpn;
        wr_lg = lg; wr_pid = pid; wr_attr = attr;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                failures++;
                $display("FAIL watchdog: got cycles=%0d exp below %0d", cycles, WATCHDOG);
                finish_run();
            end
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 0; m_epn[i] = 0; m_rpn[i] = 0; m_lg[i] = 0; m_pid[i] = 0; m_attr[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R13: outputs held at zero under reset
        checks++;
        if (hit !== 1'b0 || hit_idx !== 4'd0 || real_addr !== 32'd0 || zone_code !== 2'd0 || zone_ovr !== 1'b0) begin
            failures++;
            $display("FAIL R13: got hit=%0b idx=%0d ra=%h zc=%0d zo=%0b exp all 0",
                     hit, hit_idx, real_addr, zone_code, zone_ovr);
        end
        rst_n = 1'b1;
        @(negedge clk);
        lk_addr = 32'h0; lk_pid = 8'd0;
        tick("R13 R8 empty table");

        // R10: load all slots, slot 5 loaded invalid (R1)
        for (int i = 0; i < N; i++) begin
            set_wr(i, (i != 5), 32'(i) << 24,
                   32'h8000_0000 | (32'(15 - i) << 24) | 32'h0001_2345,
                   5'(12 + 2 * (i % 4)), (i % 3 == 0) ? 8'd0 : 8'(i),
                   {4'(i), 4'h5});
            lk_addr = (i > 0) ? (32'(i - 1) << 24) + 32'h10 : 32'h0;
            lk_pid  = 8'(i - 1);
            tick("R10 load");
        end

        // R1 R2 R3 R4: sweep every slot, tag, offset and privilege
        for (int i = 0; i < N; i++) begin
            for (int p = 0; p < 3; p++) begin
                for (int o = 0; o < 3; o++) begin
                    logic [31:0] pg;
                    pg = 32'h1 << (12 + 2 * (i % 4));
                    lk_addr = (32'(i) << 24) + ((o == 0) ? 32'h0 : (o == 1) ? pg - 1 : pg);
                    lk_pid  = (p == 0) ? 8'(i) : (p == 1) ? 8'd0 : 8'hEE;
                    lk_sup  = (o + p) % 2 == 1;
                    tick("R1 R2 R3 R4 sweep");
                end
            end
        end

        // R9: lookup while slot 12 is rewritten onto slot 3's region sees old slot 12
        set_wr(12, 1'b1, 32'h0300_0000, 32'h5550_0000, 5'd20, 8'd0, 8'h30);
        lk_addr = 32'h0C00_0010; lk_pid = 8'd12;
        tick("R9 lookup during write");
        // R5: overlap, lowest index wins
        lk_addr = 32'h0300_0100; lk_pid = 8'd9;
        tick("R5 lowest wins");
        lk_addr = 32'h0308_0040;
        tick("R5 larger page only");

        // R12: targeted invalidate clears slot 3 only; same-cycle lookup sees old (R9)
        inv_va_en = 1'b1; inv_va = 32'h0300_0010; inv_pid = 8'd0;
        lk_addr = 32'h0300_0100;
        tick("R12 R9 invalidate cycle");
        tick("R12 next slot takes over");
        // R12: tag mismatch clears nothing
        inv_va_en = 1'b1; inv_va = 32'h0700_0000; inv_pid = 8'd4;
        lk_addr = 32'h0700_0020; lk_pid = 8'd7;
        tick("R12 mismatch ignored");
        tick("R12 slot 7 kept");
        // R12: write to the matched slot wins over the invalidate
        inv_va_en = 1'b1; inv_va = 32'h0300_0010; inv_pid = 8'd0;
        set_wr(12, 1'b1, 32'h0300_0000, 32'h7770_0000, 5'd20, 8'd0, 8'hF0);
        lk_addr = 32'h0300_0100;
        tick("R12 write beats invalidate");
        lk_sup = 1'b1;
        tick("R12 new contents visible");

        // R11: flush with a same-cycle write leaves everything empty
        inv_all = 1'b1;
        set_wr(0, 1'b1, 32'h0, 32'h1234_0000, 5'd12, 8'd0, 8'h00);
        tick("R11 flush cycle");
        for (int i = 0; i < N; i++) begin
            lk_addr = (32'(i) << 24) + 32'h8; lk_pid = 8'(i);
            tick("R11 empty after flush");
        end

        // R6 R7: every zone, code and privilege
        for (int z = 0; z < 16; z++) begin
            set_wr(0, 1'b1, 32'h0, 32'h4000_0000, 5'd12, 8'd0, {4'(z), 4'hA});
            lk_addr = 32'h10; lk_pid = 8'd3; lk_sup = 1'b0;
            tick("R10 zone slot load");
            for (int c = 0; c < 4; c++) begin
                for (int s = 0; s < 2; s++) begin
                    zone_map = (32'h1B1B_1B1B & ~(32'h3 << zpos(z))) | (32'(c) << zpos(z));
                    lk_sup = s[0];
                    tick("R6 R7 zone sweep");
                end
            end
        end

        finish_run();
    end
endmodule